// File: doc/BRIEF.md
# One-Time-Programmable Setting Bank with Global Lock

This block holds twenty 10-bit setting words for a downstream converter. The words behave like fuse storage: a commit can only set bits from 0 to 1. No commit can ever clear a bit. A single lock flag sits beside the words. Once the lock is set, the whole bank is frozen and every later commit is refused.

A commit is one request cycle carrying an index, a 10-bit value and a strobe. Each data word has a live output register that drives the converter. Whenever its word is programmed, the live register takes the same merged value on the same clock edge. One cycle after each strobe, a registered status says whether the request was applied, refused because the bank is locked, or dropped because its index is out of range. A combinational read port returns any word by index, and the lock flag reads back at index 20.

Top module: `otpb_bank`

## Requirements
- R1: While `rst` is high at a rising edge, every stored word, the lock flag, every live output and `cmt_done` become 0, and `cmt_status` becomes 2'b00.
- R2: An applied commit to index k (0 to 19) sets word k to (old word k) OR `cmt_value` at the clock edge where the strobe is sampled. The new value is visible on the read port right after that edge.
- R3: A stored 1 bit never returns to 0. A commit whose value has 0 bits leaves those bits unchanged.
- R4: The live output slice `live_out[k*10 +: 10]` is updated on the same edge as word k and always equals stored word k.
- R5: While unlocked, a commit to index 20 with `cmt_value[0]`=1 sets the lock flag. With `cmt_value[0]`=0 it leaves the flag at 0. Bits 9:1 are ignored in both cases. A read at index 20 returns the flag in bit 0 and zeros above.
- R6: Once the lock flag is 1, it stays 1. Any commit to index 0 to 20 then changes no stored word, no live output and not the flag.
- R7: A commit with index 21 to 31 changes nothing. A read at index 21 to 31 returns 0.
- R8: On the cycle after each sampled strobe, `cmt_done` is 1 and `cmt_status` reports the outcome: 2'b01 applied, 2'b10 refused by lock, or 2'b11 bad index. A bad index is reported as 2'b11 even while locked. On a cycle after no strobe, `cmt_done` is 0 and `cmt_status` is 2'b00.
- R9: `rd_data` follows `rd_idx` combinationally within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmt_valid | input | 1 | Commit strobe |
| cmt_idx | input | 5 | Commit target index (0-19 words, 20 lock) |
| cmt_value | input | 10 | Commit value, OR-merged into the target |
| rd_idx | input | 5 | Read port index |
| rd_data | output | 10 | Read port data |
| live_out | output | 200 | Live converter settings, word k at bits k*10 +: 10 |
| cmt_done | output | 1 | Status valid, one cycle after a strobe |
| cmt_status | output | 2 | Commit outcome code |

## Verification
On every cycle, the bound assertions check four things. No stored bit ever falls. The live outputs match the stored words. The lock freezes both the stored words and the flag. Each strobe produces the matching status on the next cycle, with refused and bad-index outcomes leaving the storage unchanged. Other properties need the directed scenarios. These are that the OR-merge produces the exact expected word, that bits 9:1 at index 20 do nothing, that a zero bit 0 at index 20 leaves the bank unlocked, and that the read port returns the right word, flag or zero for every index. The scenarios check these against a model of the bank kept in the bench.

// File: rtl/otpb_pkg.sv
package otpb_pkg;
  localparam int unsigned OTPB_CH_N = 20;
  localparam int unsigned OTPB_DW   = 10;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_APPLIED = 2'b01,
    ST_BLOCKED = 2'b10,
    ST_BADIDX  = 2'b11
  } cmt_st_e;
endpackage

// File: rtl/otpb_gate.sv
// Decodes a commit request into per-word write enables, a lock enable
// and the outcome code reported one cycle later.
module otpb_gate
  import otpb_pkg::*;
#(
  parameter int unsigned N_CH  = OTPB_CH_N,
  parameter int unsigned IDX_W = $clog2(N_CH + 1)
) (
  input  logic             req_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             lock_i,
  output logic [N_CH-1:0]  ch_we_o,
  output logic             lock_we_o,
  output cmt_st_e          st_o
);
  localparam logic [IDX_W-1:0] LOCK_IDX = IDX_W'(N_CH);

  logic in_range;
  logic allow;

  assign in_range = (idx_i <= LOCK_IDX);
  assign allow    = req_i && in_range && !lock_i;

  for (genvar g = 0; g < int'(N_CH); g++) begin : g_dec
    assign ch_we_o[g] = allow && (idx_i == IDX_W'(g));
  end

  assign lock_we_o = allow && (idx_i == LOCK_IDX);

  always_comb begin
    if (!req_i)         st_o = ST_IDLE;
    else if (!in_range) st_o = ST_BADIDX;
    else if (lock_i)    st_o = ST_BLOCKED;
    else                st_o = ST_APPLIED;
  end
endmodule

// File: rtl/otpb_cells.sv
// Storage words with set-only merge; one register per word.
module otpb_cells #(
  parameter int unsigned N_CH = 20,
  parameter int unsigned DW   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_CH-1:0]    ch_we_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [N_CH*DW-1:0] store_o
);
  for (genvar g = 0; g < int'(N_CH); g++) begin : g_word
    logic [DW-1:0] cell_q;

    always_ff @(posedge clk) begin
      if (rst)             cell_q <= '0;
      else if (ch_we_i[g]) cell_q <= cell_q | wdata_i;
    end

    assign store_o[g*DW +: DW] = cell_q;
  end
endmodule

// File: rtl/otpb_live.sv
// Live converter registers, loaded with the merged word on each write.
module otpb_live #(
  parameter int unsigned N_CH = 20,
  parameter int unsigned DW   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_CH-1:0]    ch_we_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [N_CH*DW-1:0] store_i,
  output logic [N_CH*DW-1:0] live_o
);
  for (genvar g = 0; g < int'(N_CH); g++) begin : g_live
    logic [DW-1:0] live_q;

    always_ff @(posedge clk) begin
      if (rst)             live_q <= '0;
      else if (ch_we_i[g]) live_q <= store_i[g*DW +: DW] | wdata_i;
    end

    assign live_o[g*DW +: DW] = live_q;
  end
endmodule

// File: rtl/otpb_lock.sv
// Global freeze flag; can only be set.
module otpb_lock (
  input  logic clk,
  input  logic rst,
  input  logic we_i,
  input  logic set_bit_i,
  output logic lock_o
);
  always_ff @(posedge clk) begin
    if (rst)                    lock_o <= 1'b0;
    else if (we_i && set_bit_i) lock_o <= 1'b1;
  end
endmodule

// File: rtl/otpb_rdmux.sv
// Combinational read selector over the words and the lock flag.
module otpb_rdmux #(
  parameter int unsigned N_CH  = 20,
  parameter int unsigned DW    = 10,
  parameter int unsigned IDX_W = $clog2(N_CH + 1)
) (
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [N_CH*DW-1:0] store_i,
  input  logic               lock_i,
  output logic [DW-1:0]      data_o
);
  localparam logic [IDX_W-1:0] LOCK_IDX = IDX_W'(N_CH);

  always_comb begin
    data_o = '0;
    for (int i = 0; i < int'(N_CH); i++) begin
      if (idx_i == IDX_W'(i)) data_o = store_i[i*DW +: DW];
    end
    if (idx_i == LOCK_IDX) data_o = DW'(lock_i);
  end
endmodule

// File: rtl/otpb_bank.sv
module otpb_bank
  import otpb_pkg::*;
#(
  parameter int unsigned N_CH  = OTPB_CH_N,
  parameter int unsigned DW    = OTPB_DW,
  parameter int unsigned IDX_W = $clog2(N_CH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmt_valid,
  input  logic [IDX_W-1:0]   cmt_idx,
  input  logic [DW-1:0]      cmt_value,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [DW-1:0]      rd_data,
  output logic [N_CH*DW-1:0] live_out,
  output logic               cmt_done,
  output logic [1:0]         cmt_status
);
  logic [N_CH-1:0]    ch_we;
  logic               lock_we;
  logic               lock_q;
  logic [N_CH*DW-1:0] store_flat;
  cmt_st_e            st_next;
  cmt_st_e            st_q;

  otpb_gate #(.N_CH(N_CH), .IDX_W(IDX_W)) u_gate (
    .req_i     (cmt_valid),
    .idx_i     (cmt_idx),
    .lock_i    (lock_q),
    .ch_we_o   (ch_we),
    .lock_we_o (lock_we),
    .st_o      (st_next)
  );

  otpb_cells #(.N_CH(N_CH), .DW(DW)) u_cells (
    .clk     (clk),
    .rst     (rst),
    .ch_we_i (ch_we),
    .wdata_i (cmt_value),
    .store_o (store_flat)
  );

  otpb_live #(.N_CH(N_CH), .DW(DW)) u_live (
    .clk     (clk),
    .rst     (rst),
    .ch_we_i (ch_we),
    .wdata_i (cmt_value),
    .store_i (store_flat),
    .live_o  (live_out)
  );

  otpb_lock u_lock (
    .clk       (clk),
    .rst       (rst),
    .we_i      (lock_we),
    .set_bit_i (cmt_value[0]),
    .lock_o    (lock_q)
  );

  otpb_rdmux #(.N_CH(N_CH), .DW(DW), .IDX_W(IDX_W)) u_rd (
    .idx_i   (rd_idx),
    .store_i (store_flat),
    .lock_i  (lock_q),
    .data_o  (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmt_done <= 1'b0;
      st_q     <= ST_IDLE;
    end else begin
      cmt_done <= cmt_valid;
      st_q     <= st_next;
    end
  end

  assign cmt_status = st_q;
endmodule

// File: rtl/otpb_bank_chk.sv
module otpb_bank_chk
  import otpb_pkg::*;
#(
  parameter int unsigned N_CH  = OTPB_CH_N,
  parameter int unsigned DW    = OTPB_DW,
  parameter int unsigned IDX_W = $clog2(N_CH + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               cmt_valid,
  input logic [IDX_W-1:0]   cmt_idx,
  input logic [N_CH*DW-1:0] live_out,
  input logic               cmt_done,
  input logic [1:0]         cmt_status,
  input logic [N_CH*DW-1:0] store_flat,
  input logic               lock_q
);
  localparam logic [IDX_W-1:0] LOCK_IDX = IDX_W'(N_CH);

  logic armed  = 1'b0;
  logic armed2 = 1'b0;

  always_ff @(posedge clk) begin
    armed  <= rst ? 1'b1 : armed;
    armed2 <= armed;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (store_flat == '0) && !lock_q && (live_out == '0) && !cmt_done
            && (cmt_status == 2'b00));

  p_no_clear_r3: assert property (@(posedge clk) disable iff (rst || !armed2)
    (($past(store_flat) & ~store_flat) == '0));

  p_live_mirror_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    live_out == store_flat);

  p_lock_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q && $stable(store_flat) && $stable(live_out));

  p_badidx_r7: assert property (@(posedge clk) disable iff (rst)
    (cmt_valid && (cmt_idx > LOCK_IDX)) |=>
      $stable(store_flat) && $stable(lock_q) && cmt_done && (cmt_status == 2'b11));

  p_blocked_status_r8: assert property (@(posedge clk) disable iff (rst)
    (cmt_valid && lock_q && (cmt_idx <= LOCK_IDX)) |=> cmt_done && (cmt_status == 2'b10));

  p_idle_status_r8: assert property (@(posedge clk) disable iff (rst)
    !cmt_valid |=> !cmt_done && (cmt_status == 2'b00));
endmodule

bind otpb_bank otpb_bank_chk #(.N_CH(N_CH), .DW(DW), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmt_valid  (cmt_valid),
  .cmt_idx    (cmt_idx),
  .live_out   (live_out),
  .cmt_done   (cmt_done),
  .cmt_status (cmt_status),
  .store_flat (store_flat),
  .lock_q     (lock_q)
);

// File: tb/otpb_bank_bench.sv
`timescale 1ns/1ps
module otpb_bank_bench;
  localparam int N_CH = 20;
  localparam int DW   = 10;
  localparam int IW   = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmt_valid = 1'b0;
  logic [IW-1:0]     cmt_idx = '0;
  logic [DW-1:0]     cmt_value = '0;
  logic [IW-1:0]     rd_idx = '0;
  logic [DW-1:0]     rd_data;
  logic [N_CH*DW-1:0] live_out;
  logic              cmt_done;
  logic [1:0]        cmt_status;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [DW-1:0] m_word [N_CH];
  logic          m_lock;

  always #2.5 clk = ~clk;

  otpb_bank u_otpb_bank (
    .clk(clk), .rst(rst), .cmt_valid(cmt_valid), .cmt_idx(cmt_idx),
    .cmt_value(cmt_value), .rd_idx(rd_idx), .rd_data(rd_data),
    .live_out(live_out), .cmt_done(cmt_done), .cmt_status(cmt_status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Read port and live outputs against the model; runs between edges.
  task automatic verify_all(input string req);
    for (int i = 0; i < 32; i++) begin
      logic [DW-1:0] e;
      rd_idx = IW'(i);
      #0.1;
      if (i < N_CH)       e = m_word[i];
      else if (i == N_CH) e = DW'(m_lock);
      else                e = '0;
      check({req, " R9 read"}, 32'(rd_data), 32'(e));
      if (i < N_CH) check({req, " R4 live"}, 32'(live_out[i*DW +: DW]), 32'(m_word[i]));
    end
  endtask

  // One strobe; status checked in the cycle after the sampling edge.
  task automatic commit(input int idx, input logic [DW-1:0] val, input logic [1:0] exp_st,
                        input string req);
    @(negedge clk);
    cmt_valid = 1'b1;
    cmt_idx   = IW'(idx);
    cmt_value = val;
    @(negedge clk);
    cmt_valid = 1'b0;
    check({req, " R8 done"}, 32'(cmt_done), 32'd1);
    check({req, " R8 status"}, 32'(cmt_status), 32'(exp_st));
    if (idx <= N_CH && !m_lock) begin
      if (idx < N_CH) m_word[idx] = m_word[idx] | val;
      else if (val[0]) m_lock = 1'b1;
    end
  endtask

  task automatic t_reset;
    for (int i = 0; i < N_CH; i++) m_word[i] = '0;
    m_lock = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 done after reset", 32'(cmt_done), 32'd0);
    check("R1 status after reset", 32'(cmt_status), 32'd0);
    check("R1 live zero", 32'(live_out == '0), 32'd1);
    verify_all("R1");
  endtask

  task automatic t_or_merge;
    commit(0, 10'h155, 2'b01, "R2 ch0");
    commit(19, 10'h3FF, 2'b01, "R2 ch19");
    commit(7, 10'h001, 2'b01, "R2 ch7a");
    commit(7, 10'h200, 2'b01, "R2 ch7b");
    check("R2 ch7 merged", 32'(m_word[7]), 32'h201);
    verify_all("R2");
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    cmt_valid = 1'b1; cmt_idx = 5'd3; cmt_value = 10'h00F;
    @(negedge clk);
    check("R8 b2b first", 32'(cmt_status), 32'd1);
    cmt_idx = 5'd4; cmt_value = 10'h0F0;
    @(negedge clk);
    cmt_valid = 1'b0;
    check("R8 b2b second done", 32'(cmt_done), 32'd1);
    check("R8 b2b second", 32'(cmt_status), 32'd1);
    m_word[3] = m_word[3] | 10'h00F;
    m_word[4] = m_word[4] | 10'h0F0;
    verify_all("R2 b2b");
  endtask

  task automatic t_no_clear;
    commit(0, 10'h000, 2'b01, "R3 zero");
    verify_all("R3 zero");
    commit(0, 10'h2AA, 2'b01, "R3 fill");
    check("R3 ch0 full", 32'(m_word[0]), 32'h3FF);
    commit(19, 10'h000, 2'b01, "R3 keep19");
    verify_all("R3");
  endtask

  task automatic t_idle;
    @(negedge clk);
    check("R8 idle done", 32'(cmt_done), 32'd0);
    check("R8 idle status", 32'(cmt_status), 32'd0);
  endtask

  task automatic t_lock_zero;
    commit(N_CH, 10'h3FE, 2'b01, "R5 bit0 clear");
    rd_idx = 5'd20; #0.1;
    check("R5 lock stays 0", 32'(rd_data), 32'd0);
    commit(5, 10'h011, 2'b01, "R5 still open");
    verify_all("R5 open");
  endtask

  task automatic t_badidx;
    commit(21, 10'h3FF, 2'b11, "R7 idx21");
    commit(31, 10'h3FF, 2'b11, "R7 idx31");
    verify_all("R7");
  endtask

  task automatic t_lock;
    commit(N_CH, 10'h001, 2'b01, "R5 set lock");
    rd_idx = 5'd20; #0.1;
    check("R5 lock reads 1", 32'(rd_data), 32'd1);
    commit(1, 10'h3FF, 2'b10, "R6 ch1 blocked");
    commit(19, 10'h3FF, 2'b10, "R6 ch19 blocked");
    commit(N_CH, 10'h000, 2'b10, "R6 idx20 blocked");
    commit(25, 10'h3FF, 2'b11, "R8 bad beats lock");
    verify_all("R6");
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_or_merge();
    t_back_to_back();
    t_no_clear();
    t_idle();
    t_lock_zero();
    t_badidx();
    t_lock();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule